// File: doc/BRIEF.md
# Single-Channel Block-Transfer DMA Controller

This block copies a block of words between one peripheral and system memory on its own, so the processor does not move each word. Software first loads four write-only registers: the device location, the memory start address, the word count and a command word. The command word selects the direction and the arbitration style, and it also starts the transfer. Once started, the controller waits for the peripheral to report it is ready. It then asks the processor for the system bus with a three-wire request/grant/acknowledge exchange. While it holds the bus, it acts as bus master and drives the memory address and the single-cycle read or write strobes.

Each word takes two bus cycles. The first cycle fetches the word into a one-word holding register, from the device or from memory. The second cycle delivers it to the other side. In burst style the controller keeps the bus for the whole block. In cycle-steal style it gives the bus back after every word and arbitrates again for the next one. When the last word has been delivered, the controller raises an interrupt line. That line stays high until software clears it.

Top module: `dma_ctrl`

## Requirements
- R1: Register offsets on `reg_addr`: 0 = device location (shown on `dev_addr`), 1 = memory start address, 2 = word count, 3 = command. Command bits: [0] direction, [1] style (0 burst, 1 cycle steal), [2] go, [3] interrupt clear.
- R2: After go, and before every word in cycle-steal style, `br` stays low until `dev_ready` has been sampled high.
- R3: `br` stays high until `bg` is sampled high. On the next edge, `bgack` rises and `br` falls. While `bgack` is low, `mem_rd` and `mem_wr` are low and `mem_addr` is 0, however long the grant is withheld.
- R4: Direction 0 (device to memory): a cycle with `dev_ack` captures `dev_rdata`. The next cycle pulses `mem_wr` with that word on `mem_wdata`.
- R5: Direction 1 (memory to device): a cycle with `mem_rd` captures `mem_rdata`. The next cycle pulses `dev_ack` with that word on `dev_wdata`.
- R6: Word k of a block uses memory address start+k, and exactly count words are moved.
- R7: In burst style, `bgack` rises once per block and stays high to the end. If `dev_ready` is low in a fetch cycle, the controller waits there and keeps the bus.
- R8: In cycle-steal style, `bgack` falls after every word, giving one full request/grant/acknowledge exchange per word.
- R9: On the edge that ends the last delivery cycle, `irq` rises and `bgack` falls. `irq` stays high until a command write with the clear bit set.
- R10: While a block is in progress, writes to registers 0 to 3 do not change the configuration and do not start a new transfer.
- R11: Go with a word count of 0 raises `irq` on the same edge and never asserts `br`.
- R12: If a completion and a clear request happen in the same cycle, the completion wins and `irq` is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| irq | output | 1 | Block-complete interrupt |
| br | output | 1 | Bus request |
| bg | input | 1 | Bus grant from processor |
| bgack | output | 1 | Bus grant acknowledge (controller owns bus) |
| mem_addr | output | 16 | Memory address, 0 when not bus master |
| mem_rd | output | 1 | Single-cycle memory read strobe |
| mem_wr | output | 1 | Single-cycle memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data (same cycle) |
| dev_addr | output | 16 | Device location |
| dev_ready | input | 1 | Peripheral ready |
| dev_ack | output | 1 | Peripheral word strobe |
| dev_wdata | output | 16 | Data to peripheral |
| dev_rdata | input | 16 | Data from peripheral |

## Verification
Completion and interrupt clear can land in the same cycle. A single command write that carries both the clear bit and go, with a word count of zero, makes both happen at once. This is done while an earlier interrupt is still pending, and `irq` must read high afterwards. A clear with a non-zero count must instead leave `irq` low until the new block finishes. The bench also writes registers while a block is being moved. It judges these writes by the data that reaches memory and by a later go that reuses the stored configuration.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAITDEV,
        ST_REQ,
        ST_READ,
        ST_WRITE
    } dma_state_e;

    localparam int REG_DEV = 0;
    localparam int REG_MEM = 1;
    localparam int REG_LEN = 2;
    localparam int REG_CMD = 3;

    localparam int CMD_DIR  = 0;
    localparam int CMD_MODE = 1;
    localparam int CMD_GO   = 2;
    localparam int CMD_CLR  = 3;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int LW  = 16,
    parameter int RAW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic           busy_i,
    input  logic           done_i,
    output logic [AW-1:0]  dev_loc_o,
    output logic [AW-1:0]  mem_base_o,
    output logic [LW-1:0]  len_o,
    output logic           dir_o,
    output logic           mode_o,
    output logic           go_o,
    output logic           irq_o
);
    localparam logic [RAW-1:0] A_DEV = RAW'(REG_DEV);
    localparam logic [RAW-1:0] A_MEM = RAW'(REG_MEM);
    localparam logic [RAW-1:0] A_LEN = RAW'(REG_LEN);
    localparam logic [RAW-1:0] A_CMD = RAW'(REG_CMD);

    typedef struct packed {
        logic [AW-1:0] dev;
        logic [AW-1:0] mem;
        logic [LW-1:0] len;
        logic          dir;
        logic          mode;
        logic          irq;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic cmd_wr, clr_req;

    always_comb begin
        cfg_d   = cfg_q;
        cmd_wr  = we && (waddr == A_CMD);
        clr_req = cmd_wr && wdata[CMD_CLR];
        go_o    = cmd_wr && wdata[CMD_GO] && !busy_i;
        if (we && !busy_i) begin
            case (waddr)
                A_DEV: cfg_d.dev = wdata[AW-1:0];
                A_MEM: cfg_d.mem = wdata[AW-1:0];
                A_LEN: cfg_d.len = wdata[LW-1:0];
                A_CMD: begin
                    cfg_d.dir  = wdata[CMD_DIR];
                    cfg_d.mode = wdata[CMD_MODE];
                end
                default: ;
            endcase
        end
        if (clr_req) cfg_d.irq = 1'b0;
        if (done_i)  cfg_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign dev_loc_o  = cfg_q.dev;
    assign mem_base_o = cfg_q.mem;
    assign len_o      = cfg_q.len;
    assign dir_o      = cfg_q.dir;
    assign mode_o     = cfg_q.mode;
    assign irq_o      = cfg_q.irq;

    // R9 R12
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> irq_o);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_req) |=> irq_o);

    // R10
    busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(cfg_q.mem) && $stable(cfg_q.len) &&
                    $stable(cfg_q.dir) && $stable(cfg_q.mode) && $stable(cfg_q.dev)));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [LW-1:0] len_i,
    input  logic [AW-1:0] base_i,
    input  logic          dir_i,
    input  logic          mode_i,
    input  logic          dev_ready_i,
    input  logic          bg_i,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic [DW-1:0] dev_rdata_i,
    output logic          br_o,
    output logic          bgack_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          dev_ack_o,
    output logic [DW-1:0] dev_wdata_o,
    output logic          busy_o,
    output logic          done_o
);
    typedef struct packed {
        dma_state_e    st;
        logic [AW-1:0] addr;
        logic [LW-1:0] cnt;
        logic [DW-1:0] word;
    } eng_t;

    eng_t eng_d, eng_q;
    logic last_word;

    assign last_word = (eng_q.cnt == LW'(1));

    always_comb begin
        eng_d       = eng_q;
        br_o        = 1'b0;
        bgack_o     = 1'b0;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_wdata_o = '0;
        dev_ack_o   = 1'b0;
        dev_wdata_o = '0;
        done_o      = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                if (go_i) begin
                    if (len_i == '0) begin
                        done_o = 1'b1;
                    end else begin
                        eng_d.st   = ST_WAITDEV;
                        eng_d.addr = base_i;
                        eng_d.cnt  = len_i;
                    end
                end
            end
            ST_WAITDEV: begin
                if (dev_ready_i) eng_d.st = ST_REQ;
            end
            ST_REQ: begin
                br_o = 1'b1;
                if (bg_i) eng_d.st = ST_READ;
            end
            ST_READ: begin
                bgack_o = 1'b1;
                if (dev_ready_i) begin
                    if (dir_i) begin
                        mem_rd_o   = 1'b1;
                        eng_d.word = mem_rdata_i;
                    end else begin
                        dev_ack_o  = 1'b1;
                        eng_d.word = dev_rdata_i;
                    end
                    eng_d.st = ST_WRITE;
                end
            end
            ST_WRITE: begin
                bgack_o = 1'b1;
                if (dir_i) begin
                    dev_ack_o   = 1'b1;
                    dev_wdata_o = eng_q.word;
                end else begin
                    mem_wr_o    = 1'b1;
                    mem_wdata_o = eng_q.word;
                end
                eng_d.addr = eng_q.addr + 1'b1;
                eng_d.cnt  = eng_q.cnt - 1'b1;
                if (last_word) begin
                    done_o   = 1'b1;
                    eng_d.st = ST_IDLE;
                end else if (mode_i) begin
                    eng_d.st = ST_WAITDEV;
                end else begin
                    eng_d.st = ST_READ;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, addr: '0, cnt: '0, word: '0};
        else        eng_q <= eng_d;
    end

    assign mem_addr_o = bgack_o ? eng_q.addr : '0;
    assign busy_o     = (eng_q.st != ST_IDLE);

    // R2
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(br_o) |-> $past(dev_ready_i));

    // R3
    br_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_o && !bg_i) |=> br_o);

    // R3
    grant_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bgack_o) |-> ($past(bg_i) && $past(br_o) && !br_o));

    // R3
    no_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bgack_o |-> (!mem_rd_o && !mem_wr_o && mem_addr_o == '0));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_WRITE) |=> (eng_q.addr == $past(eng_q.addr) + 1'b1));

    // R7
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_WRITE && !mode_i && !last_word) |=> bgack_o);

    // R8
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_WRITE && mode_i && !last_word) |=> !bgack_o);

    // R11
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !busy_o && len_i == '0) |=> !busy_o);
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int LW  = 16,
    parameter int RAW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic           irq,
    output logic           br,
    input  logic           bg,
    output logic           bgack,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [AW-1:0]  dev_addr,
    input  logic           dev_ready,
    output logic           dev_ack,
    output logic [DW-1:0]  dev_wdata,
    input  logic [DW-1:0]  dev_rdata
);
    logic [AW-1:0] base_w;
    logic [LW-1:0] len_w;
    logic          dir_w, mode_w, go_w, busy_w, done_w;

    dma_regs #(.AW(AW), .DW(DW), .LW(LW), .RAW(RAW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .waddr     (reg_addr),
        .wdata     (reg_wdata),
        .busy_i    (busy_w),
        .done_i    (done_w),
        .dev_loc_o (dev_addr),
        .mem_base_o(base_w),
        .len_o     (len_w),
        .dir_o     (dir_w),
        .mode_o    (mode_w),
        .go_o      (go_w),
        .irq_o     (irq)
    );

    dma_engine #(.AW(AW), .DW(DW), .LW(LW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go_w),
        .len_i      (len_w),
        .base_i     (base_w),
        .dir_i      (dir_w),
        .mode_i     (mode_w),
        .dev_ready_i(dev_ready),
        .bg_i       (bg),
        .mem_rdata_i(mem_rdata),
        .dev_rdata_i(dev_rdata),
        .br_o       (br),
        .bgack_o    (bgack),
        .mem_addr_o (mem_addr),
        .mem_rd_o   (mem_rd),
        .mem_wr_o   (mem_wr),
        .mem_wdata_o(mem_wdata),
        .dev_ack_o  (dev_ack),
        .dev_wdata_o(dev_wdata),
        .busy_o     (busy_w),
        .done_o     (done_w)
    );
endmodule

// File: tb/test_dma_ctrl.sv
module test_dma_ctrl;
    localparam logic [15:0] DEVLOC = 16'h0C35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        irq, br, bgack, mem_rd, mem_wr, dev_ack;
    logic        bg = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, dev_addr, dev_wdata, dev_rdata;
    logic        dev_ready = 1'b0;

    logic [15:0] mem [256];
    logic [15:0] dev_seq = '0;
    logic        bg_en = 1'b1;
    logic        ready_lvl = 1'b1;
    logic        stall_mode = 1'b0;
    logic        cur_dir = 1'b0;
    int          cyc = 0;
    int          vectors = 0;
    int          fails = 0;
    int          grants = 0;
    int          br_cycles = 0;
    logic        bgack_prev = 1'b0;
    logic        bg_prev = 1'b0;

    typedef struct {
        bit          is_mem;
        logic [15:0] addr;
        logic [15:0] data;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    dma_ctrl i_dma_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq(irq), .br(br), .bg(bg), .bgack(bgack),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_addr(dev_addr),
        .dev_ready(dev_ready), .dev_ack(dev_ack), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    assign dev_rdata = 16'h5000 + dev_seq;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h3000 ^ (16'(i) * 16'd7);
    end

    // processor and peripheral models
    always @(posedge clk) begin
        cyc <= cyc + 1;
        bg <= br && bg_en;
        dev_ready <= stall_mode ? (cyc[1:0] != 2'd0) : ready_lvl;
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (dev_ack && !cur_dir) dev_seq <= dev_seq + 16'd1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard and watches the handshake
    always @(negedge clk) begin
        if (rst_n) begin
            if (bgack && !bgack_prev) begin
                grants++;
                check(bg_prev && !br, "R3 acknowledge after grant, request dropped", {bg_prev, br}, 2'b10);
            end
            if ((mem_wr || mem_rd || mem_addr != 0) && !bgack)
                check(1'b0, "R3 bus driven without acknowledge", {mem_wr, mem_rd}, 0);
            if (br) br_cycles++;
            if (mem_wr || (dev_ack && cur_dir && bgack && !mem_rd)) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R6 extra word moved", mem_addr, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (it.is_mem) begin
                        check(mem_wr, "R4 memory write strobe", mem_wr, 1);
                        check(mem_addr == it.addr, "R6 memory address", mem_addr, it.addr);
                        check(mem_wdata == it.data, "R4 word into memory", mem_wdata, it.data);
                    end else begin
                        check(dev_ack && !mem_wr, "R5 device strobe", dev_ack, 1);
                        check(dev_wdata == it.data, "R5 word to device", dev_wdata, it.data);
                    end
                end
            end
            bgack_prev = bgack;
            bg_prev = bg;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // opt: 0 plain, 1 late ready, 2 withheld grant, 3 writes while busy, 4 reuse stored config
    task automatic run_block(input bit dir, input bit mode, input logic [15:0] base,
                             input int len, input int opt);
        int g0;
        if (opt != 4) begin
            wr(2'd0, DEVLOC);
            wr(2'd1, base);
            wr(2'd2, 16'(len));
        end
        check(dev_addr == DEVLOC, "R1 device location register", dev_addr, DEVLOC);
        cur_dir = dir;
        for (int i = 0; i < len; i++) begin
            item_t it;
            it.is_mem = !dir;
            it.addr = base + 16'(i);
            it.data = dir ? mem[8'(base + 16'(i))] : (dev_seq + 16'h5000 + 16'(i));
            sb.push_back(it);
        end
        g0 = grants;
        ready_lvl = (opt != 1);
        if (opt == 2) bg_en = 1'b0;
        wr(2'd3, 16'h000C | {14'd0, mode, dir});
        check(!irq, "R9 clear with go drops interrupt", irq, 0);
        if (opt == 1) begin
            repeat (6) @(negedge clk);
            check(!br, "R2 no request before device ready", br, 0);
            ready_lvl = 1'b1;
        end
        if (opt == 2) begin
            repeat (20) @(negedge clk);
            check(br && !bgack && !mem_wr && !mem_rd && mem_addr == 0,
                  "R3 request held, bus idle without grant", {br, bgack, mem_wr, mem_rd}, 4'b1000);
            bg_en = 1'b1;
        end
        if (opt == 3) begin
            repeat (3) @(negedge clk);
            wr(2'd1, 16'h00F0);
            wr(2'd2, 16'd9);
            wr(2'd3, 16'h0004 | {15'd0, !dir});
        end
        for (int k = 0; k < 3000 && !irq; k++) @(negedge clk);
        check(irq, "R9 interrupt at block end", irq, 1);
        check(!bgack && !br, "R9 bus released at block end", {bgack, br}, 0);
        check(sb.size() == 0, "R6 word count", sb.size(), 0);
        check(grants - g0 == (mode ? len : 1), mode ? "R8 one exchange per word" : "R7 single grant for block",
              grants - g0, mode ? len : 1);
        repeat (4) @(negedge clk);
        check(irq, "R9 interrupt held until clear", irq, 1);
        wr(2'd3, 16'h0008);
        check(!irq, "R9 clear bit drops interrupt", irq, 0);
    endtask

    initial begin : watchdog
        wait (cyc >= 100000);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!irq && !br && !bgack, "R9 reset state of irq/br/bgack", {irq, br, bgack}, 0);
        check(!mem_wr && !mem_rd && !dev_ack && mem_addr == 0, "R3 reset bus idle", {mem_wr, mem_rd, dev_ack}, 0);

        run_block(1'b0, 1'b0, 16'h0010, 4, 1);   // R2 R4 R7
        run_block(1'b1, 1'b0, 16'h0040, 5, 0);   // R5 R7
        run_block(1'b0, 1'b1, 16'h0020, 3, 0);   // R4 R8
        run_block(1'b1, 1'b1, 16'h0060, 4, 1);   // R5 R8 R2
        stall_mode = 1'b1;
        run_block(1'b0, 1'b0, 16'h0080, 6, 0);   // R7 stall keeps the bus
        stall_mode = 1'b0;
        run_block(1'b0, 1'b0, 16'h0090, 2, 2);   // R3 withheld grant
        run_block(1'b0, 1'b0, 16'h00A0, 6, 3);   // R10 writes during transfer
        run_block(1'b0, 1'b0, 16'h00A0, 6, 4);   // R10 stored config unchanged

        // R11 zero-length block
        b0 = br_cycles;
        wr(2'd2, 16'd0);
        wr(2'd3, 16'h0004);
        check(irq, "R11 zero count interrupts at once", irq, 1);
        repeat (5) @(negedge clk);
        check(br_cycles == b0, "R11 no request for zero count", br_cycles - b0, 0);

        // R12 completion and clear in the same cycle
        wr(2'd3, 16'h000C);
        check(irq, "R12 completion beats clear", irq, 1);
        wr(2'd3, 16'h0008);
        check(!irq, "R12 plain clear afterwards", irq, 0);

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule